// File: doc/BRIEF.md
# Encoder Position Counter with Index Reset

This block holds the absolute shaft position of a rotary encoder as a 32-bit count. An upstream quadrature decoder supplies single-cycle count strobes, each with a direction bit. Forward strobes step the count up and reverse strobes step it down. The count wraps inside a window that runs from zero to a programmable top value. Software can overwrite the count at any time through a load port.

A mode input selects how the encoder's once-per-revolution marker is used. With the mode off, the marker is only reported and the count ignores it. With the mode on, every marker forces the count to zero. If the top value is then set to one less than the number of counted edges per turn, the count becomes an angle measured from the home position. A registered event output mirrors each marker. A sticky flag shows that a marker has arrived since counting was enabled, which tells software that the count is now absolute.

Top module: `enc_pos_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `position` becomes 0 and both `index_event` and `index_seen` become 0.
- R2: With `enable` high and no load or index reset in the cycle, a strobe on `cnt_pulse` with `cnt_fwd`=1 and `position` below `max_pos` makes `position` one larger at the next edge. An enabled cycle with no strobe leaves `position` unchanged.
- R3: With `enable` high and no load or index reset in the cycle, a strobe with `cnt_fwd`=0 and `position` not 0 makes `position` one smaller at the next edge.
- R4: A forward strobe while `position` is at or above `max_pos` makes `position` 0 at the next edge.
- R5: A reverse strobe while `position` is 0 makes `position` equal to `max_pos` at the next edge.
- R6: With `idx_reset_mode`=0, `index_pulse` has no effect on `position`.
- R7: With `enable` high and `idx_reset_mode`=1, `index_pulse` makes `position` 0 at the next edge, including when a count strobe arrives in the same cycle.
- R8: `load_en` high makes `position` equal to `load_val` at the next edge. This holds whatever `enable`, the index input and the count inputs are doing in that cycle.
- R9: With `enable` low and `load_en` low, `position` holds, whatever is on `cnt_pulse` and `index_pulse`.
- R10: `index_event` is high for exactly the cycle after a cycle in which `index_pulse` and `enable` were both high, in either mode.
- R11: `index_seen` goes to 1 the cycle after an enabled index pulse and stays 1 while `enable` stays high. A cycle with `enable` low clears it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows counting and index handling |
| cnt_pulse | input | 1 | Single-cycle count strobe from the decoder |
| cnt_fwd | input | 1 | Direction of the strobe, 1 = forward |
| index_pulse | input | 1 | Once-per-revolution marker, one cycle wide |
| idx_reset_mode | input | 1 | 1 = marker zeroes the count |
| max_pos | input | 32 | Top of the wrap window |
| load_en | input | 1 | Software write strobe for the count |
| load_val | input | 32 | Value written on `load_en` |
| position | output | 32 | Current count |
| index_event | output | 1 | Registered marker indication |
| index_seen | output | 1 | Sticky: marker seen since enable |

## Verification
Several sources can claim the count in the same cycle: a software load, an index reset and a count strobe. The bench draws all three from a seeded random stream and also sets up directed cycles where they coincide, both at the top of the window and at zero. Each cycle, a bench model applies the stated priority of load over index over count. The count it predicts is compared with `position` one edge later.

// File: rtl/enc_pos_pkg.sv
package enc_pos_pkg;

    localparam int unsigned POS_W_DEF = 32;

    // What the position register does on the coming edge.
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_LOAD = 3'd1,
        ACT_ZERO = 3'd2,
        ACT_INC  = 3'd3,
        ACT_DEC  = 3'd4
    } pos_act_e;

    // Per-cycle request bundle seen by the arbiter.
    typedef struct packed {
        logic load;
        logic enable;
        logic idx_mode;
        logic index;
        logic pulse;
        logic fwd;
    } pos_req_t;

    // Priority: software load, then index reset, then counting.
    function automatic pos_act_e pick_action(pos_req_t r);
        pos_act_e a;
        if (r.load)
            a = ACT_LOAD;
        else if (!r.enable)
            a = ACT_HOLD;
        else if (r.idx_mode && r.index)
            a = ACT_ZERO;
        else if (r.pulse)
            a = r.fwd ? ACT_INC : ACT_DEC;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/enc_pos_arbiter.sv
module enc_pos_arbiter
    import enc_pos_pkg::*;
(
    input  pos_req_t req,
    output pos_act_e act
);

    always_comb begin
        act = pick_action(req);
    end

endmodule

// File: rtl/enc_pos_stepper.sv
module enc_pos_stepper
    import enc_pos_pkg::*;
#(
    parameter int unsigned POS_W = POS_W_DEF
) (
    input  pos_act_e         act,
    input  logic [POS_W-1:0] cur,
    input  logic [POS_W-1:0] max_pos,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] nxt
);

    localparam logic [POS_W-1:0] ONE  = POS_W'(1);
    localparam logic [POS_W-1:0] ZERO = '0;

    logic at_top;
    logic at_bottom;

    assign at_top    = (cur >= max_pos);
    assign at_bottom = (cur == ZERO);

    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = load_val;
            ACT_ZERO: nxt = ZERO;
            ACT_INC:  nxt = at_top ? ZERO : cur + ONE;
            ACT_DEC:  nxt = at_bottom ? max_pos : cur - ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/enc_pos_index_track.sv
module enc_pos_index_track (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic index_pulse,
    output logic index_event,
    output logic index_seen
);

    logic hit;
    assign hit = enable && index_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_event <= 1'b0;
            index_seen  <= 1'b0;
        end else begin
            index_event <= hit;
            index_seen  <= enable ? (index_seen || index_pulse) : 1'b0;
        end
    end

    // R10: event only follows an enabled marker
    a_r10_event_source: assert property (@(posedge clk) disable iff (rst)
        index_event |-> $past(enable && index_pulse));

    // R11: flag sticks while enabled
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (enable && index_seen) |=> index_seen);

    // R11: disable clears the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !index_seen);

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
    import enc_pos_pkg::*;
#(
    parameter int unsigned POS_W = POS_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cnt_pulse,
    input  logic             cnt_fwd,
    input  logic             index_pulse,
    input  logic             idx_reset_mode,
    input  logic [POS_W-1:0] max_pos,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] position,
    output logic             index_event,
    output logic             index_seen
);

    pos_req_t         req;
    pos_act_e         act;
    logic [POS_W-1:0] pos_nxt;

    always_comb begin
        req          = '0;
        req.load     = load_en;
        req.enable   = enable;
        req.idx_mode = idx_reset_mode;
        req.index    = index_pulse;
        req.pulse    = cnt_pulse;
        req.fwd      = cnt_fwd;
    end

    enc_pos_arbiter u_arb (
        .req (req),
        .act (act)
    );

    enc_pos_stepper #(.POS_W(POS_W)) u_step (
        .act      (act),
        .cur      (position),
        .max_pos  (max_pos),
        .load_val (load_val),
        .nxt      (pos_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            position <= '0;
        else
            position <= pos_nxt;
    end

    enc_pos_index_track u_idx (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .index_pulse (index_pulse),
        .index_event (index_event),
        .index_seen  (index_seen)
    );

    logic count_ok;
    assign count_ok = enable && !load_en && !(idx_reset_mode && index_pulse) && cnt_pulse;

    // R2: forward step below the top
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (count_ok && cnt_fwd && position < max_pos) |=> position == $past(position) + POS_W'(1));

    // R3: reverse step above zero
    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (count_ok && !cnt_fwd && position != '0) |=> position == $past(position) - POS_W'(1));

    // R4: forward wrap to zero
    a_r4_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (count_ok && cnt_fwd && position >= max_pos) |=> position == '0);

    // R5: reverse wrap to the top
    a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (count_ok && !cnt_fwd && position == '0) |=> position == $past(max_pos));

    // R7: index reset wins over counting
    a_r7_index_zero: assert property (@(posedge clk) disable iff (rst)
        (enable && !load_en && idx_reset_mode && index_pulse) |=> position == '0);

    // R8: load overrides everything
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> position == $past(load_val));

    // R9: disabled counter holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load_en) |=> $stable(position));

endmodule

// File: tb/test_enc_pos_counter.sv
module test_enc_pos_counter;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         enable, cnt_pulse, cnt_fwd, index_pulse, idx_reset_mode, load_en;
    logic [W-1:0] max_pos, load_val;
    logic [W-1:0] position;
    logic         index_event, index_seen;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [W-1:0] m_pos;
    logic         m_evt, m_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_pos_counter #(.POS_W(W)) i_enc_pos_counter (
        .clk(clk), .rst(rst), .enable(enable), .cnt_pulse(cnt_pulse),
        .cnt_fwd(cnt_fwd), .index_pulse(index_pulse), .idx_reset_mode(idx_reset_mode),
        .max_pos(max_pos), .load_en(load_en), .load_val(load_val),
        .position(position), .index_event(index_event), .index_seen(index_seen)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Which requirement governs the position for the current inputs.
    function automatic string pos_tag();
        if (rst) return "R1";
        if (load_en) return "R8";
        if (!enable) return "R9";
        if (idx_reset_mode && index_pulse) return "R7";
        if (cnt_pulse && cnt_fwd) return (m_pos >= max_pos) ? "R4" : "R2";
        if (cnt_pulse) return (m_pos == '0) ? "R5" : "R3";
        if (index_pulse) return "R6";
        return "R2";
    endfunction

    function automatic logic [W-1:0] model_next();
        if (rst) return '0;
        if (load_en) return load_val;
        if (!enable) return m_pos;
        if (idx_reset_mode && index_pulse) return '0;
        if (cnt_pulse && cnt_fwd) return (m_pos >= max_pos) ? '0 : m_pos + 1;
        if (cnt_pulse) return (m_pos == '0) ? max_pos : m_pos - 1;
        return m_pos;
    endfunction

    // Apply current inputs across one edge and compare.
    task automatic step();
        string tag;
        logic [W-1:0] np;
        logic ne, ns;
        tag = pos_tag();
        np = model_next();
        ne = rst ? 1'b0 : (enable && index_pulse);
        ns = rst ? 1'b0 : (enable ? (m_seen || index_pulse) : 1'b0);
        @(posedge clk);
        #1;
        m_pos = np; m_evt = ne; m_seen = ns;
        check(tag, position, m_pos);
        check(rst ? "R1" : "R10", W'(index_event), W'(m_evt));
        check(rst ? "R1" : "R11", W'(index_seen), W'(m_seen));
        @(negedge clk);
        rst = 0; load_en = 0; cnt_pulse = 0; index_pulse = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        m_pos = 'x; m_evt = 1'bx; m_seen = 1'bx;
        rst = 1; enable = 0; cnt_pulse = 0; cnt_fwd = 0; index_pulse = 0;
        idx_reset_mode = 0; load_en = 0; load_val = 0; max_pos = 9;
        @(negedge clk);
        // R1 reset state
        step();
        rst = 1; step();

        // R2 / R4 forward through the top (max 9)
        enable = 1;
        for (int i = 0; i < 12; i++) begin cnt_pulse = 1; cnt_fwd = 1; step(); end
        // R5 reverse through zero
        load_en = 1; load_val = 0; step();
        cnt_pulse = 1; cnt_fwd = 0; step();
        check("R5", position, 32'd9);
        // R3
        cnt_pulse = 1; cnt_fwd = 0; step();
        check("R3", position, 32'd8);
        // R6 index ignored in mode 0
        index_pulse = 1; step();
        check("R6", position, 32'd8);
        // R7 index plus count in mode 1
        idx_reset_mode = 1; index_pulse = 1; cnt_pulse = 1; cnt_fwd = 1; step();
        check("R7", position, 32'd0);
        // R7 index plus reverse at zero
        index_pulse = 1; cnt_pulse = 1; cnt_fwd = 0; step();
        check("R7", position, 32'd0);
        // R8 load beats index and count
        load_en = 1; load_val = 32'd5; index_pulse = 1; cnt_pulse = 1; step();
        check("R8", position, 32'd5);
        // R9 disabled: counts and index ignored, load still works
        enable = 0; cnt_pulse = 1; cnt_fwd = 1; index_pulse = 1; step();
        check("R9", position, 32'd5);
        check("R11", W'(index_seen), 32'd0);
        load_en = 1; load_val = 32'd20; step();
        check("R8", position, 32'd20);
        // R4 above the top after a load wraps to zero
        enable = 1; cnt_pulse = 1; cnt_fwd = 1; step();
        check("R4", position, 32'd0);
        // max of zero corner
        max_pos = 0;
        cnt_pulse = 1; cnt_fwd = 1; step();
        cnt_pulse = 1; cnt_fwd = 0; step();
        // large top value
        max_pos = 32'hFFFF_FFFF; load_en = 1; load_val = 32'hFFFF_FFFE; step();
        cnt_pulse = 1; cnt_fwd = 1; step();
        cnt_pulse = 1; cnt_fwd = 1; step();
        check("R4", position, 32'd0);
        cnt_pulse = 1; cnt_fwd = 0; step();
        check("R5", position, 32'hFFFF_FFFF);

        // Random mix
        max_pos = 15;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 300) == 0) max_pos = $urandom % 24;
            if (($urandom % 200) == 0) idx_reset_mode = ~idx_reset_mode;
            enable      = ($urandom % 10) != 0;
            cnt_pulse   = ($urandom % 10) < 7;
            cnt_fwd     = ($urandom % 3) != 0;
            index_pulse = ($urandom % 20) == 0;
            load_en     = ($urandom % 40) == 0;
            load_val    = $urandom % 30;
            if (($urandom % 500) == 0) rst = 1;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule